// File: doc/BRIEF.md
# Self-Describing Write Probe Target

The block is a small memory-mapped target for exercising low-level bus writes. It decodes a window of up to 4 KB behind a simple slave port. The port carries a word address, byte enables, write data, read and write strobes, and read data. Software picks a test by writing its number into a select byte at the bottom of the window. It then reads back three values that describe the write to perform: the access width, the byte offset inside the window, and the data value. It also reads a short text name for the test.

Software then issues that write. A hit counter shows whether the write arrived with the right width, address, lane placement and value. Tests are numbered upward from zero with no gaps. A probing routine can therefore step through test numbers until the width field reports an unsupported code.

The block has three tests. Test 0 is a one-byte write to offset 0x041 with value 0x5A. Test 1 is a two-byte write to offset 0x082 with value 0xBEEF. Test 2 is a four-byte write to offset 0x0C0 with value 0xC0FFEE42.

Top module: `io_probe_target`

## Requirements
- R1: After reset the current test is 0, the hit counter is 0 and the read data output is 0.
- R2: Word 0x00 reads back as follows. Bits 15:8 hold the width code of the current test: 1 for a byte write, 2 for a 16-bit write, 4 for a 32-bit write, and 0 for any test number above 2. Bits 7:0 and 31:16 read 0.
- R3: Word 0x04 reads the byte offset of the current test and word 0x08 reads its data value. Tests 0, 1 and 2 give 0x041/0x5A, 0x082/0xBEEF and 0x0C0/0xC0FFEE42. An unsupported test reads 0 in both words.
- R4: The test name starts at byte 0x10. It is stored little-endian, one character per byte, and ends with a zero byte. Words 0x10 and 0x14 read 0x45545942 and 0x0052575F for test 0 ("BYTE_WR"), 0x464C4148 and 0x0052575F for test 1 ("HALF_WR"), and 0x44524F57 and 0x0052575F for test 2 ("WORD_WR"). An unsupported test reads 0 in both words.
- R5: A write counts as a hit and adds one to the counter at word 0x0C when all of the following are true. It targets the word that holds the current test's offset. Its byte enables equal the width mask shifted to lane offset[1:0]. The enabled lanes, taken from that lane upward, carry the test's data value.
- R6: A write with a wrong byte enable pattern, wrong data or wrong word address does not change the counter. Neither does any write while an unsupported test is selected.
- R7: A write to word 0x00 with byte enable 0 set loads the current test number from write data bits 7:0. The same write clears the hit counter to 0.
- R8: The hit counter stops at its all-ones value (HIT_W bits wide, zero-extended to 32 bits) and does not wrap.
- R9: Reads of word addresses 0x18 and above return 0. Writes to any word other than word 0x00 and the current test's word change no readable state.
- R10: Read data is registered. It updates on the clock edge that ends a cycle with bus_rd high, and holds its value while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_word | input | ADDR_W-2 (10) | Word address, byte address bits 11:2 |
| bus_be | input | 4 | Byte enables, bit i covers write data bits 8i+7:8i |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_rdata | output | 32 | Registered read data |

## Verification
A write in cycle N changes the select register and the counter at the edge that ends cycle N. A read issued in a later cycle therefore already sees the new value. Read data appears one edge after the read strobe.

The bench drives every strobe for exactly one cycle starting at a falling edge. It samples bus_rdata at the next falling edge, after the capturing rising edge has settled. Each expected value accounts for exactly one register stage per read and one per write.

The hold property of R10 is checked by sampling again after an idle edge with a changed address. The rejected-write cases of R6 and R9 are followed by a read of the counter or of the word that could have been touched, before any further write.

// File: rtl/io_probe_pkg.sv
package io_probe_pkg;

  localparam int NUM_TESTS = 3;

  typedef struct packed {
    logic [7:0]  width;
    logic [31:0] offset;
    logic [31:0] data;
    logic [31:0] name_lo;
    logic [31:0] name_hi;
  } test_desc_t;

  // Descriptor of a test number; numbers at or above NUM_TESTS are empty.
  function automatic test_desc_t lookup_test(input logic [7:0] num);
    test_desc_t d;
    d = '0;
    case (num)
      8'd0: begin
        d.width   = 8'd1;
        d.offset  = 32'h0000_0041;
        d.data    = 32'h0000_005A;
        d.name_lo = 32'h4554_5942;
        d.name_hi = 32'h0052_575F;
      end
      8'd1: begin
        d.width   = 8'd2;
        d.offset  = 32'h0000_0082;
        d.data    = 32'h0000_BEEF;
        d.name_lo = 32'h464C_4148;
        d.name_hi = 32'h0052_575F;
      end
      8'd2: begin
        d.width   = 8'd4;
        d.offset  = 32'h0000_00C0;
        d.data    = 32'hC0FF_EE42;
        d.name_lo = 32'h4452_4F57;
        d.name_hi = 32'h0052_575F;
      end
      default: d = '0;
    endcase
    return d;
  endfunction

  // Byte-lane mask of a width code before lane shifting.
  function automatic logic [3:0] width_mask(input logic [7:0] width);
    case (width)
      8'd1:    return 4'b0001;
      8'd2:    return 4'b0011;
      8'd4:    return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/io_probe_select.sv
module io_probe_select (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel_wr,
  input  logic [7:0]                sel_num,
  output io_probe_pkg::test_desc_t  desc
);
  import io_probe_pkg::*;

  logic [7:0] cur_q;
  logic [7:0] cur_d;
  logic       cur_en;

  always_comb begin
    cur_en = sel_wr;
    cur_d  = sel_num;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= 8'd0;
    else if (cur_en) cur_q <= cur_d;
  end

  always_comb desc = lookup_test(cur_q);

endmodule

// File: rtl/io_probe_hit.sv
module io_probe_hit #(
  parameter int WORD_W = 10,
  parameter int HIT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  input  logic              sel_wr,
  input  logic [7:0]        width,
  input  logic [31:0]       offset,
  input  logic [31:0]       data,
  output logic              hit,
  output logic [HIT_W-1:0]  hit_cnt
);
  import io_probe_pkg::*;

  localparam logic [HIT_W-1:0] CNT_MAX = {HIT_W{1'b1}};

  logic [3:0]       base_mask;
  logic [3:0]       exp_be;
  logic [31:0]      bit_mask;
  logic [31:0]      lane_data;
  logic             addr_ok;
  logic             data_ok;
  logic             be_ok;
  logic [HIT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    base_mask = width_mask(width);
    exp_be    = base_mask << offset[1:0];
  end

  for (genvar i = 0; i < 4; i++) begin : g_lane_mask
    assign bit_mask[8*i +: 8] = {8{base_mask[i]}};
  end

  always_comb begin
    lane_data = wr_data >> {offset[1:0], 3'b000};
    addr_ok   = ({{(30-WORD_W){1'b0}}, wr_word} == offset[31:2]);
    data_ok   = ((lane_data & bit_mask) == (data & bit_mask));
    be_ok     = (base_mask != 4'b0000) && (wr_be == exp_be);
    hit       = wr_en && !sel_wr && addr_ok && be_ok && data_ok;
  end

  always_comb begin
    cnt_en = sel_wr || (hit && (hit_cnt != CNT_MAX));
    cnt_d  = sel_wr ? '0 : hit_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hit_cnt <= '0;
    else if (cnt_en) hit_cnt <= cnt_d;
  end

endmodule

// File: rtl/io_probe_readmux.sv
module io_probe_readmux #(
  parameter int WORD_W = 10,
  parameter int HIT_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [WORD_W-1:0]         rd_word,
  input  io_probe_pkg::test_desc_t  desc,
  input  logic [HIT_W-1:0]          hit_cnt,
  output logic [31:0]               rdata
);
  localparam int W_HDR  = 0;
  localparam int W_OFS  = 1;
  localparam int W_DAT  = 2;
  localparam int W_CNT  = 3;
  localparam int W_NM0  = 4;
  localparam int W_NM1  = 5;

  logic [31:0] rdata_d;

  always_comb begin
    case (int'(rd_word))
      W_HDR:   rdata_d = {16'h0000, desc.width, 8'h00};
      W_OFS:   rdata_d = desc.offset;
      W_DAT:   rdata_d = desc.data;
      W_CNT:   rdata_d = 32'(hit_cnt);
      W_NM0:   rdata_d = desc.name_lo;
      W_NM1:   rdata_d = desc.name_hi;
      default: rdata_d = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 32'h0;
    else if (rd_en) rdata <= rdata_d;
  end

endmodule

// File: rtl/io_probe_target.sv
module io_probe_target #(
  parameter  int WIN_BYTES = 4096,
  parameter  int HIT_W     = 32,
  localparam int ADDR_W    = $clog2(WIN_BYTES),
  localparam int WORD_W    = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] bus_word,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata
);
  import io_probe_pkg::*;

  test_desc_t       desc;
  logic             sel_wr;
  logic             hit;
  logic [HIT_W-1:0] hit_cnt;

  always_comb sel_wr = bus_wr && (bus_word == '0) && bus_be[0];

  io_probe_select u_select (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_wr  (sel_wr),
    .sel_num (bus_wdata[7:0]),
    .desc    (desc)
  );

  io_probe_hit #(.WORD_W(WORD_W), .HIT_W(HIT_W)) u_hit (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr),
    .wr_word (bus_word),
    .wr_be   (bus_be),
    .wr_data (bus_wdata),
    .sel_wr  (sel_wr),
    .width   (desc.width),
    .offset  (desc.offset),
    .data    (desc.data),
    .hit     (hit),
    .hit_cnt (hit_cnt)
  );

  io_probe_readmux #(.WORD_W(WORD_W), .HIT_W(HIT_W)) u_read (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (bus_rd),
    .rd_word (bus_word),
    .desc    (desc),
    .hit_cnt (hit_cnt),
    .rdata   (bus_rdata)
  );

endmodule

// File: rtl/io_probe_target_chk.sv
module io_probe_target_chk #(
  parameter int HIT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [3:0]       bus_be,
  input logic [31:0]      bus_rdata,
  input logic             sel_wr,
  input logic             hit,
  input logic [HIT_W-1:0] hit_cnt
);
  localparam logic [HIT_W-1:0] CNT_MAX = {HIT_W{1'b1}};

  assert_select_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (hit_cnt == '0));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cnt == CNT_MAX) && !sel_wr |=> (hit_cnt == CNT_MAX));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !sel_wr && (hit_cnt != CNT_MAX) |=> (hit_cnt == $past(hit_cnt) + 1'b1));

  assert_count_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hit && !sel_wr |=> $stable(hit_cnt));

  assert_hit_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> bus_wr && (bus_be != 4'b0000));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind io_probe_target io_probe_target_chk #(.HIT_W(HIT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_be    (bus_be),
  .bus_rdata (bus_rdata),
  .sel_wr    (sel_wr),
  .hit       (hit),
  .hit_cnt   (hit_cnt)
);

// File: tb/tb_io_probe_target.sv
module tb_io_probe_target;
  localparam int HW = 4;

  logic        clk;
  logic        rst_n;
  logic [9:0]  bus_word;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  io_probe_target #(.WIN_BYTES(4096), .HIT_W(HW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] addr, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_word = addr[11:2]; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'b0;
  endtask

  task automatic rd(input logic [11:0] addr, output logic [31:0] d);
    @(negedge clk);
    bus_word = addr[11:2]; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 rdata after reset", bus_rdata, 32'h0);
    rd(12'h000, v); check("R1 test 0 current", v, 32'h0000_0100);
    rd(12'h00C, v); check("R1 counter zero", v, 32'h0);
  endtask

  task automatic t_describe(input logic [7:0] num, input logic [31:0] w,
                            input logic [31:0] ofs, input logic [31:0] dat,
                            input logic [31:0] n0, input logic [31:0] n1);
    logic [31:0] v;
    wr(12'h000, 4'b0001, {24'hFFFFFF, num});
    rd(12'h000, v); check("R2 width field", v, {16'h0, w[7:0], 8'h0});
    rd(12'h004, v); check("R3 offset", v, ofs);
    rd(12'h008, v); check("R3 data", v, dat);
    rd(12'h010, v); check("R4 name low", v, n0);
    rd(12'h014, v); check("R4 name high", v, n1);
  endtask

  task automatic t_hits();
    logic [31:0] v;
    wr(12'h000, 4'b0001, 32'h0);
    wr(12'h040, 4'b0010, 32'h0000_5A00);
    rd(12'h00C, v); check("R5 byte hit", v, 32'd1);
    wr(12'h040, 4'b0011, 32'h0000_5A00);
    rd(12'h00C, v); check("R6 wrong be", v, 32'd1);
    wr(12'h040, 4'b0010, 32'h0000_5B00);
    rd(12'h00C, v); check("R6 wrong data", v, 32'd1);
    wr(12'h044, 4'b0010, 32'h0000_5A00);
    rd(12'h00C, v); check("R6 wrong word", v, 32'd1);
    wr(12'h000, 4'b0001, 32'h1);
    wr(12'h080, 4'b1100, 32'hBEEF_0000);
    rd(12'h00C, v); check("R5 half hit", v, 32'd1);
    wr(12'h000, 4'b0001, 32'h2);
    wr(12'h0C0, 4'b1111, 32'hC0FF_EE42);
    wr(12'h0C0, 4'b1111, 32'hC0FF_EE42);
    rd(12'h00C, v); check("R5 word hits", v, 32'd2);
    wr(12'h000, 4'b0001, 32'h2);
    rd(12'h00C, v); check("R7 select clears", v, 32'd0);
    wr(12'h000, 4'b0001, 32'h7);
    wr(12'h000, 4'b0000, 32'h0);
    wr(12'h0C0, 4'b1111, 32'h0);
    rd(12'h00C, v); check("R6 unsupported no hit", v, 32'd0);
  endtask

  task automatic t_saturate();
    logic [31:0] v;
    wr(12'h000, 4'b0001, 32'h2);
    for (int i = 0; i < 18; i++) wr(12'h0C0, 4'b1111, 32'hC0FF_EE42);
    rd(12'h00C, v); check("R8 saturates", v, 32'h0000_000F);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(12'h000, 4'b0001, 32'h1);
    wr(12'h004, 4'b1111, 32'hFFFF_FFFF);
    rd(12'h004, v); check("R9 offset unchanged", v, 32'h0000_0082);
    wr(12'h000, 4'b0010, 32'h0000_0000);
    rd(12'h000, v); check("R9 select needs lane 0", v, 32'h0000_0200);
    wr(12'h100, 4'b1111, 32'h1234_5678);
    rd(12'h100, v); check("R9 unmapped write/read", v, 32'h0);
    rd(12'h018, v); check("R9 past name", v, 32'h0);
    rd(12'hFFC, v); check("R9 top of window", v, 32'h0);
  endtask

  task automatic t_latency();
    logic [31:0] v;
    rd(12'h004, v); check("R10 read value", v, 32'h0000_0082);
    @(negedge clk); bus_word = 10'h002;
    @(negedge clk); check("R10 hold while idle", bus_rdata, 32'h0000_0082);
  endtask

  initial begin
    rst_n = 1'b0; bus_word = '0; bus_be = '0; bus_wdata = '0;
    bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_describe(8'd0, 32'd1, 32'h41, 32'h5A, 32'h4554_5942, 32'h0052_575F);
    t_describe(8'd1, 32'd2, 32'h82, 32'hBEEF, 32'h464C_4148, 32'h0052_575F);
    t_describe(8'd2, 32'd4, 32'hC0, 32'hC0FF_EE42, 32'h4452_4F57, 32'h0052_575F);
    t_describe(8'd3, 32'd0, 32'h0, 32'h0, 32'h0, 32'h0);
    t_describe(8'd255, 32'd0, 32'h0, 32'h0, 32'h0, 32'h0);
    t_hits();
    t_saturate();
    t_ignored();
    t_latency();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule